// File: doc/BRIEF.md
# PWM Force and Reload Router

This block groups four PWM counter channels that share one set of control
routes. Each channel picks one of eight events to raise its force-update
strobe: its own force bit, reload or sync; the matching event of channel 0;
or one of two external strobes. The reload route is chosen per channel. A
channel either uses its own wrap, gated by its own load-enable flag, or uses
channel 0's wrap, gated by channel 0's flag. Routes that would make channel 0
point at itself are tied low.

All counting runs on the single system clock. The clock selection picks a
count-enable strobe: every cycle, an external enable, or channel 0's enable.
Each counter runs from its active start value up to its active limit and then
wraps back. The start and limit values are double-buffered. New buffer values
become active only on a wrap that occurs while the load-enable flag is set,
and that transfer clears the flag. A force event can also reload the counter
with its start value.

Top module: `pwm_route_top`

## Requirements
- R1: Force select 3'b000 passes the channel's own force bit, 3'b100 its own sync strobe, 3'b110 the pulse derived from the external force input and 3'b111 the pulse derived from the external sync input, all combinationally to `forceOut`.
- R2: In channels 1 to 3, force select 3'b001 follows channel 0's force bit and 3'b101 follows channel 0's sync strobe.
- R3: In channel 0, force selects 3'b001, 3'b011 and 3'b101 hold `forceOut[0]` at 0.
- R4: Force select 3'b010 fires on the channel's own wrap whatever its load-enable flag holds. Force select 3'b011 fires on channel 0's wrap only while channel 0's load-enable flag is set.
- R5: With clock select 2'b00 the counter advances by one every cycle. In the cycle where it equals the active limit (a wrap), it loads the active start value instead.
- R6: Clock select 2'b01 advances the counter only in cycles where `extCntEn` is 1. Clock select 2'b10 advances it in the same cycles as channel 0. Clock select 2'b11, and 2'b10 in channel 0, freeze it.
- R7: `ldokSet[i]` sets the channel's load-enable flag. A wrap while the flag is set copies `initBuf`/`modBuf` into the active start and limit and clears the flag. When the flag is set and cleared in the same cycle, the set wins. Buffer values have no effect at any other time.
- R8: With reload select 1, a channel transfers its buffers on channel 0's wrap while channel 0's flag is set, and its own flag is ignored. In channel 0, reload select 1 disables transfers.
- R9: A force event with `forceInitEn[i]` set loads the active start value (the value before any transfer in that same cycle) into the counter. This takes priority over counting.
- R10: External force and sync inputs pass through two synchronizing flops. Each rising edge gives exactly one pulse cycle, starting in the cycle after the second clock edge that samples the new level.
- R11: After reset every counter is 0, the active start is 0, the active limit is all ones and every load-enable flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extCntEn | input | 1 | External count-enable strobe (synchronous) |
| extForce | input | 1 | External force input (asynchronous level) |
| extSync | input | 1 | External sync input (asynchronous level) |
| forceBit | input | NUM_SM | Per-channel force strobe |
| syncIn | input | NUM_SM | Per-channel sync strobe |
| ldokSet | input | NUM_SM | Per-channel load-enable set strobe |
| forceSel | input | NUM_SM x 3 | Per-channel force source select |
| reloadSel | input | NUM_SM | Per-channel reload route select |
| clkSel | input | NUM_SM x 2 | Per-channel count-enable source select |
| forceInitEn | input | NUM_SM | Per-channel enable for counter load on force |
| initBuf | input | NUM_SM x CNT_W | Buffered start values |
| modBuf | input | NUM_SM x CNT_W | Buffered limit values |
| cnt | output | NUM_SM x CNT_W | Counter values |
| forceOut | output | NUM_SM | Force-update strobes |

## Verification
The assertions check on every cycle that channel 0's self-routes stay low,
that a frozen channel holds its count, that the own-force route follows its
bit, and that an external force event lasts one cycle on the force strobe.
Buffered transfers, the set-over-clear rule of the load-enable flag, routes
through channel 0's wrap, and counter loads on force involve internal state
that no port shows directly. Only the bench's scenarios show these. The bench
compares every channel each cycle against its own model, first in directed
sequences and then across randomized configurations.

// File: rtl/pwm_route_pkg.sv
package pwm_route_pkg;

  typedef enum logic [2:0] {
    FS_OWN_FORCE    = 3'b000,
    FS_MST_FORCE    = 3'b001,
    FS_OWN_RELOAD   = 3'b010,
    FS_MST_RELOAD   = 3'b011,
    FS_OWN_SYNC     = 3'b100,
    FS_MST_SYNC     = 3'b101,
    FS_EXT_FORCE    = 3'b110,
    FS_EXT_SYNC     = 3'b111
  } forceSrc_e;

  typedef enum logic [1:0] {
    CS_SYSTEM = 2'b00,
    CS_EXTERN = 2'b01,
    CS_MASTER = 2'b10,
    CS_NONE   = 2'b11
  } clkSrc_e;

  typedef struct packed {
    logic cntEn;
    logic wrapNow;
    logic reloadQ;
    logic forceLoad;
  } chanStrb_t;

endpackage

// File: rtl/pwm_route_edge_sync.sv
module pwm_route_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic pulse
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], asyncIn};
      prevQ <= syncQ[LAST];
    end
  end

  assign pulse = syncQ[LAST] & ~prevQ;
endmodule

// File: rtl/pwm_route_ctrl.sv
module pwm_route_ctrl
  import pwm_route_pkg::*;
#(
  parameter int NUM_SM = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   extCntEn,
  input  logic                   extForce,
  input  logic                   extSync,
  input  logic [NUM_SM-1:0]      forceBit,
  input  logic [NUM_SM-1:0]      syncIn,
  input  logic [NUM_SM-1:0]      ldokSet,
  input  logic [NUM_SM-1:0][2:0] forceSel,
  input  logic [NUM_SM-1:0]      reloadSel,
  input  logic [NUM_SM-1:0][1:0] clkSel,
  input  logic [NUM_SM-1:0]      forceInitEn,
  input  logic [NUM_SM-1:0]      atMod,
  output chanStrb_t [NUM_SM-1:0] strb,
  output logic [NUM_SM-1:0]      forceOut
);

  logic              extForcePulse;
  logic              extSyncPulse;
  logic [NUM_SM-1:0] cntEn;
  logic [NUM_SM-1:0] wrap;
  logic [NUM_SM-1:0] reloadQ;
  logic [NUM_SM-1:0] ldok;

  pwm_route_edge_sync #(.STAGES(2)) u_forceSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(extForce),
    .pulse  (extForcePulse)
  );

  pwm_route_edge_sync #(.STAGES(2)) u_syncSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(extSync),
    .pulse  (extSyncPulse)
  );

  // Channel 0 enable first: the other channels may borrow it.
  always_comb begin
    unique case (clkSel[0])
      CS_SYSTEM: cntEn[0] = 1'b1;
      CS_EXTERN: cntEn[0] = extCntEn;
      default:   cntEn[0] = 1'b0;
    endcase
  end

  for (genvar i = 1; i < NUM_SM; i++) begin : g_en
    always_comb begin
      unique case (clkSel[i])
        CS_SYSTEM: cntEn[i] = 1'b1;
        CS_EXTERN: cntEn[i] = extCntEn;
        CS_MASTER: cntEn[i] = cntEn[0];
        default:   cntEn[i] = 1'b0;
      endcase
    end
  end

  assign wrap = cntEn & atMod;

  for (genvar i = 0; i < NUM_SM; i++) begin : g_route
    localparam bit IS_MASTER = (i == 0);
    logic mstForce, mstReloadQ, mstSync;

    assign mstForce   = IS_MASTER ? 1'b0 : forceBit[0];
    assign mstReloadQ = IS_MASTER ? 1'b0 : (wrap[0] & ldok[0]);
    assign mstSync    = IS_MASTER ? 1'b0 : syncIn[0];

    always_comb begin
      unique case (forceSel[i])
        FS_OWN_FORCE:  forceOut[i] = forceBit[i];
        FS_MST_FORCE:  forceOut[i] = mstForce;
        FS_OWN_RELOAD: forceOut[i] = wrap[i];
        FS_MST_RELOAD: forceOut[i] = mstReloadQ;
        FS_OWN_SYNC:   forceOut[i] = syncIn[i];
        FS_MST_SYNC:   forceOut[i] = mstSync;
        FS_EXT_FORCE:  forceOut[i] = extForcePulse;
        default:       forceOut[i] = extSyncPulse;
      endcase
    end

    assign reloadQ[i] = reloadSel[i] ? mstReloadQ : (wrap[i] & ldok[i]);

    always_ff @(posedge clk) begin
      if (!rstN)
        ldok[i] <= 1'b0;
      else if (ldokSet[i])
        ldok[i] <= 1'b1;
      else if (reloadQ[i])
        ldok[i] <= 1'b0;
    end

    assign strb[i].cntEn     = cntEn[i];
    assign strb[i].wrapNow   = wrap[i];
    assign strb[i].reloadQ   = reloadQ[i];
    assign strb[i].forceLoad = forceOut[i] & forceInitEn[i];
  end

endmodule

// File: rtl/pwm_route_datapath.sv
module pwm_route_datapath
  import pwm_route_pkg::*;
#(
  parameter int NUM_SM = 4,
  parameter int CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  chanStrb_t [NUM_SM-1:0]     strb,
  input  logic [NUM_SM-1:0][CNT_W-1:0] initBuf,
  input  logic [NUM_SM-1:0][CNT_W-1:0] modBuf,
  output logic [NUM_SM-1:0][CNT_W-1:0] cnt,
  output logic [NUM_SM-1:0]          atMod
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  for (genvar i = 0; i < NUM_SM; i++) begin : g_chan
    logic [CNT_W-1:0] initAct;
    logic [CNT_W-1:0] modAct;
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        initAct <= '0;
        modAct  <= '1;
      end else if (strb[i].reloadQ) begin
        initAct <= initBuf[i];
        modAct  <= modBuf[i];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        cntQ <= '0;
      else if (strb[i].forceLoad)
        cntQ <= initAct;
      else if (strb[i].wrapNow)
        cntQ <= initAct;
      else if (strb[i].cntEn)
        cntQ <= cntQ + ONE;
    end

    assign atMod[i] = (cntQ == modAct);
    assign cnt[i]   = cntQ;
  end

endmodule

// File: rtl/pwm_route_top.sv
module pwm_route_top
  import pwm_route_pkg::*;
#(
  parameter int NUM_SM = 4,
  parameter int CNT_W  = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         extCntEn,
  input  logic                         extForce,
  input  logic                         extSync,
  input  logic [NUM_SM-1:0]            forceBit,
  input  logic [NUM_SM-1:0]            syncIn,
  input  logic [NUM_SM-1:0]            ldokSet,
  input  logic [NUM_SM-1:0][2:0]       forceSel,
  input  logic [NUM_SM-1:0]            reloadSel,
  input  logic [NUM_SM-1:0][1:0]       clkSel,
  input  logic [NUM_SM-1:0]            forceInitEn,
  input  logic [NUM_SM-1:0][CNT_W-1:0] initBuf,
  input  logic [NUM_SM-1:0][CNT_W-1:0] modBuf,
  output logic [NUM_SM-1:0][CNT_W-1:0] cnt,
  output logic [NUM_SM-1:0]            forceOut
);

  chanStrb_t [NUM_SM-1:0] strb;
  logic [NUM_SM-1:0]      atMod;

  pwm_route_ctrl #(.NUM_SM(NUM_SM)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .extCntEn   (extCntEn),
    .extForce   (extForce),
    .extSync    (extSync),
    .forceBit   (forceBit),
    .syncIn     (syncIn),
    .ldokSet    (ldokSet),
    .forceSel   (forceSel),
    .reloadSel  (reloadSel),
    .clkSel     (clkSel),
    .forceInitEn(forceInitEn),
    .atMod      (atMod),
    .strb       (strb),
    .forceOut   (forceOut)
  );

  pwm_route_datapath #(.NUM_SM(NUM_SM), .CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .initBuf(initBuf),
    .modBuf (modBuf),
    .cnt    (cnt),
    .atMod  (atMod)
  );

endmodule

// File: rtl/pwm_route_chk.sv
module pwm_route_chk #(
  parameter int NUM_SM = 4,
  parameter int CNT_W  = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_SM-1:0]            forceBit,
  input logic [NUM_SM-1:0][2:0]       forceSel,
  input logic [NUM_SM-1:0][1:0]       clkSel,
  input logic [NUM_SM-1:0]            forceInitEn,
  input logic [NUM_SM-1:0][CNT_W-1:0] cnt,
  input logic [NUM_SM-1:0]            forceOut
);

  AST_SM0_SELF_ROUTE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (forceSel[0] == 3'b001 || forceSel[0] == 3'b011 || forceSel[0] == 3'b101)
      |-> !forceOut[0]); // R3

  AST_SM0_MASTER_CLK_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel[0] == 2'b10 && !(forceOut[0] && forceInitEn[0]))
      |=> $stable(cnt[0])); // R6

  for (genvar i = 0; i < NUM_SM; i++) begin : g_chk
    AST_RESERVED_CLK_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
      (clkSel[i] == 2'b11 && !(forceOut[i] && forceInitEn[i]))
        |=> $stable(cnt[i])); // R6

    AST_OWN_FORCE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
      (forceSel[i] == 3'b000) |-> (forceOut[i] == forceBit[i])); // R1

    AST_EXT_FORCE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
      (forceSel[i] == 3'b110 && forceOut[i])
        |=> !(forceSel[i] == 3'b110 && forceOut[i])); // R10
  end

endmodule

bind pwm_route_top pwm_route_chk #(.NUM_SM(NUM_SM), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .forceBit   (forceBit),
  .forceSel   (forceSel),
  .clkSel     (clkSel),
  .forceInitEn(forceInitEn),
  .cnt        (cnt),
  .forceOut   (forceOut)
);

// File: tb/pwm_route_top_tb.sv
module pwm_route_top_tb;
  localparam int NUM_SM = 4;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extCntEn, extForce, extSync;
  logic [NUM_SM-1:0] forceBit, syncIn, ldokSet, reloadSel, forceInitEn;
  logic [NUM_SM-1:0][2:0] forceSel;
  logic [NUM_SM-1:0][1:0] clkSel;
  logic [NUM_SM-1:0][CNT_W-1:0] initBuf, modBuf;
  logic [NUM_SM-1:0][CNT_W-1:0] cnt;
  logic [NUM_SM-1:0] forceOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_route_top #(.NUM_SM(NUM_SM), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .extCntEn(extCntEn), .extForce(extForce),
    .extSync(extSync), .forceBit(forceBit), .syncIn(syncIn), .ldokSet(ldokSet),
    .forceSel(forceSel), .reloadSel(reloadSel), .clkSel(clkSel),
    .forceInitEn(forceInitEn), .initBuf(initBuf), .modBuf(modBuf),
    .cnt(cnt), .forceOut(forceOut)
  );

  // Reference model state
  logic [CNT_W-1:0] mCnt [NUM_SM];
  logic [CNT_W-1:0] mInit[NUM_SM];
  logic [CNT_W-1:0] mMod [NUM_SM];
  logic             mLdok[NUM_SM];
  logic [2:0]       mEf, mEs;
  logic             mEn[NUM_SM], mWrap[NUM_SM], mForce[NUM_SM], mRel[NUM_SM];

  task automatic modelReset();
    for (int i = 0; i < NUM_SM; i++) begin
      mCnt[i] = '0; mInit[i] = '0; mMod[i] = '1; mLdok[i] = 1'b0;
    end
    mEf = '0; mEs = '0;
  endtask

  task automatic modelComb();
    logic efp, esp;
    efp = mEf[1] & ~mEf[2];
    esp = mEs[1] & ~mEs[2];
    for (int i = 0; i < NUM_SM; i++) begin
      case (clkSel[i])
        2'd0: mEn[i] = 1'b1;
        2'd1: mEn[i] = extCntEn;
        2'd2: mEn[i] = (i == 0) ? 1'b0 : mEn[0];
        default: mEn[i] = 1'b0;
      endcase
      mWrap[i] = mEn[i] && (mCnt[i] == mMod[i]);
    end
    for (int i = 0; i < NUM_SM; i++) begin
      case (forceSel[i])
        3'd0: mForce[i] = forceBit[i];
        3'd1: mForce[i] = (i != 0) && forceBit[0];
        3'd2: mForce[i] = mWrap[i];
        3'd3: mForce[i] = (i != 0) && mWrap[0] && mLdok[0];
        3'd4: mForce[i] = syncIn[i];
        3'd5: mForce[i] = (i != 0) && syncIn[0];
        3'd6: mForce[i] = efp;
        default: mForce[i] = esp;
      endcase
      mRel[i] = reloadSel[i] ? ((i != 0) && mWrap[0] && mLdok[0])
                             : (mWrap[i] && mLdok[i]);
    end
  endtask

  task automatic modelUpdate();
    for (int i = 0; i < NUM_SM; i++) begin
      if (mForce[i] && forceInitEn[i]) mCnt[i] = mInit[i];
      else if (mWrap[i])               mCnt[i] = mInit[i];
      else if (mEn[i])                 mCnt[i] = mCnt[i] + 1'b1;
      if (mRel[i]) begin
        mInit[i] = initBuf[i];
        mMod[i]  = modBuf[i];
      end
      if (ldokSet[i])    mLdok[i] = 1'b1;
      else if (mRel[i])  mLdok[i] = 1'b0;
    end
    mEf = {mEf[1:0], extForce};
    mEs = {mEs[1:0], extSync};
  endtask

  function automatic string forceTag(int i, logic [2:0] sel);
    if (i == 0 && (sel == 3'd1 || sel == 3'd3 || sel == 3'd5)) return "R3";
    if (sel == 3'd2 || sel == 3'd3) return "R4";
    if (sel == 3'd1 || sel == 3'd5) return "R2";
    return "R1";
  endfunction

  // Called just after a negedge with inputs set; returns at the next negedge.
  task automatic step(input string tag);
    string t;
    #1;
    modelComb();
    for (int i = 0; i < NUM_SM; i++) begin
      t = (tag == "") ? forceTag(i, forceSel[i]) : tag;
      checks++;
      if (forceOut[i] !== mForce[i]) begin
        errors++;
        $display("FAIL %s forceOut[%0d] actual=%0b expected=%0b", t, i, forceOut[i], mForce[i]);
      end
      t = (tag == "") ? ((clkSel[i] == 2'd0) ? "R5" : "R6") : tag;
      checks++;
      if (cnt[i] !== mCnt[i]) begin
        errors++;
        $display("FAIL %s cnt[%0d] actual=%0d expected=%0d", t, i, cnt[i], mCnt[i]);
      end
    end
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic clearStrobes();
    forceBit = '0; syncIn = '0; ldokSet = '0;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    extCntEn = 0; extForce = 0; extSync = 0;
    clearStrobes();
    forceSel = '0; reloadSel = '0; clkSel = '0; forceInitEn = '0;
    initBuf = '0; modBuf = '0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset state
    checks++;
    if (cnt !== '0) begin
      errors++;
      $display("FAIL R11 cnt actual=%h expected=0", cnt);
    end
    step("R11");

    // R7: only channel 1 has its flag set; limit transfer on its wrap at 255
    for (int i = 0; i < NUM_SM; i++) begin
      initBuf[i] = 8'd2; modBuf[i] = 8'd5; forceSel[i] = 3'b111;
    end
    ldokSet[1] = 1'b1;
    step("R7");
    clearStrobes();
    repeat (300) step("R7");
    checks++;
    if (!(cnt[1] >= 8'd2 && cnt[1] <= 8'd5) || cnt[0] <= 8'd5) begin
      errors++;
      $display("FAIL R7 cnt1=%0d cnt0=%0d expected cnt1 in 2..5, cnt0 above 5", cnt[1], cnt[0]);
    end
    // buffer change after flag cleared must not apply
    modBuf[1] = 8'd40;
    repeat (20) step("R7");

    // R8: channel 2 follows channel 0's reload, channel 0 self-route disabled for 3
    reloadSel = 4'b1100;
    forceSel[2] = 3'b011;
    initBuf[2] = 8'd7; modBuf[2] = 8'd9;
    ldokSet[0] = 1'b1;
    step("R8");
    clearStrobes();
    repeat (280) step("R8");

    // R9: force load with init enable
    forceInitEn = 4'b1111;
    forceSel = {3'b001, 3'b001, 3'b000, 3'b000};
    repeat (6) step("R9");
    forceBit[0] = 1'b1; forceBit[1] = 1'b1;
    step("R9");
    clearStrobes();
    repeat (4) step("R9");
    forceInitEn = '0;

    // R10: external force and sync edges
    forceSel = {3'b111, 3'b110, 3'b111, 3'b110};
    extForce = 1'b1;
    repeat (6) step("R10");
    extSync = 1'b1;
    repeat (3) step("R10");
    extForce = 1'b0; extSync = 1'b0;
    repeat (4) step("R10");

    // Randomized configurations
    for (int ph = 0; ph < 40; ph++) begin
      for (int i = 0; i < NUM_SM; i++) begin
        forceSel[i]    = 3'($urandom_range(0, 7));
        clkSel[i]      = 2'($urandom_range(0, 3));
        reloadSel[i]   = 1'($urandom_range(0, 1));
        forceInitEn[i] = 1'($urandom_range(0, 1));
      end
      for (int c = 0; c < 50; c++) begin
        extCntEn = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 3) == 0) extForce = ~extForce;
        if ($urandom_range(0, 3) == 0) extSync  = ~extSync;
        for (int i = 0; i < NUM_SM; i++) begin
          forceBit[i] = ($urandom_range(0, 7) == 0);
          syncIn[i]   = ($urandom_range(0, 7) == 0);
          ldokSet[i]  = ($urandom_range(0, 5) == 0);
          if ($urandom_range(0, 9) == 0) begin
            initBuf[i] = 8'($urandom_range(0, 3));
            modBuf[i]  = 8'($urandom_range(3, 24));
          end
        end
        step("");
      end
    end

    done = 1'b1;
    finishRun();
  end

endmodule